// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Per-Character Error Tags

This block receives asynchronous serial characters on one input line. It counts an external tick that runs at sixteen times the bit rate, finds the falling edge of a start bit and confirms it half a bit later. It then samples each data bit, the optional parity bit and the first stop bit at the middle of the bit. A frame configuration word sets the character length, the parity mode and the stop-bit setting.

Each finished character goes into a two-deep holding buffer along with its own two error tags. The read word holds the data, a parity-error tag and a framing-error tag, so software can tell which character was bad. A break on the line reaches the buffer as a character with zero data and the framing tag set. A read strobe removes the oldest character. A status output stays high while the buffer holds anything. A character that finds the buffer full is dropped, and a one-cycle overflow pulse reports the loss.

Top module: `uart_rxt_top`

## Requirements
- R1: `cfg_word[3:0]` holds the character length minus three. The values 2, 3, 4 and 5 select 5, 6, 7 and 8 data bits. A value below 2 acts as 5 and a value above 5 acts as 8. Bits arrive least significant first and are placed right-aligned in `rd_word[8:0]`, with the unused upper data bits at zero.
- R2: `cfg_word[9:8]` selects the parity mode: 2'b00 none, 2'b10 even, 2'b11 odd. The code 2'b01 acts as none. When the received parity bit does not match, `rd_word[14]` is set for that character. With no parity, bit 14 is always zero.
- R3: The first stop bit is sampled at its middle. If it is low, `rd_word[15]` is set for that character. A break (all-zero data with a low stop bit) is stored as an ordinary entry reading 16'h8000, plus the parity tag if parity is wrong.
- R4: Only the first stop bit is checked. The stop setting in `cfg_word[13:12]` (2'b00 half, 2'b01 one, 2'b11 two) has no effect on reception, so back-to-back frames with a single stop bit are accepted even when two stop bits are configured.
- R5: A low level on the line starts a frame only if the line is still low eight ticks later. A shorter low pulse returns the receiver to idle and stores nothing.
- R6: The buffer holds two characters and returns them oldest first. `data_valid` is high exactly while the buffer is not empty.
- R7: A one-cycle `rd_pop` removes the oldest entry. `rd_word` always shows the oldest entry and reads zero when the buffer is empty. A pop while empty has no effect.
- R8: A character that completes while the buffer is full and no pop happens in the same cycle is discarded. `overflow` pulses high for one cycle, and the stored entries are unchanged.
- R9: After reset the buffer is empty, `data_valid`, `overflow` and `rd_word` are zero, and the receiver is idle.
- R10: Bits 13:9 of `rd_word` always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Sample enable, sixteen pulses per bit time |
| rxd | input | 1 | Serial input line, idle high |
| cfg_word | input | 16 | Frame configuration: length, parity, stop setting |
| rd_pop | input | 1 | Remove the oldest buffered character |
| rd_word | output | 16 | Oldest character: data 8:0, parity tag 14, framing tag 15 |
| data_valid | output | 1 | Buffer holds at least one character |
| overflow | output | 1 | One-cycle pulse when a character was dropped |

## Verification
The hardest condition to reach is a character that completes while both buffer slots are occupied. This happens only after three full frames with no reads in between. The bench sends three frames in a row without popping, counts overflow pulses, and then drains the buffer to show that the first two characters were kept in order. A second difficult case is a low stop bit that is followed by a line still low for part of a bit. That low level must be rejected as a false start after the framing error is stored. The bad-stop vectors create this condition, and a separate short glitch checks the false-start path from the idle state.

// File: rtl/uart_rxt_pkg.sv
package uart_rxt_pkg;

    localparam int DATA_W  = 9;
    localparam int WORD_W  = 16;
    localparam int MIN_LEN = 5;
    localparam int MAX_LEN = 8;

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_EVEN = 2'b10,
        PAR_ODD  = 2'b11
    } par_mode_e;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP
    } rx_state_e;

    typedef struct packed {
        logic              ferr;
        logic              perr;
        logic [DATA_W-1:0] data;
    } rx_entry_t;

    function automatic logic [3:0] decode_len(input logic [3:0] field);
        logic [3:0] len;
        if (field < 4'(MIN_LEN - 3)) begin
            len = 4'(MIN_LEN);
        end else if (field > 4'(MAX_LEN - 3)) begin
            len = 4'(MAX_LEN);
        end else begin
            len = field + 4'd3;
        end
        return len;
    endfunction

    function automatic par_mode_e decode_par(input logic [1:0] field);
        par_mode_e m;
        case (field)
            2'b10:   m = PAR_EVEN;
            2'b11:   m = PAR_ODD;
            default: m = PAR_NONE;
        endcase
        return m;
    endfunction

    function automatic logic [WORD_W-1:0] pack_word(input rx_entry_t e);
        return {e.ferr, e.perr, {(WORD_W - DATA_W - 2){1'b0}}, e.data};
    endfunction

endpackage

// File: rtl/uart_rxt_sync.sv
module uart_rxt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb begin
                sh_d = din;
            end
        end else begin : g_chain
            always_comb begin
                sh_d = {sh_q[STAGES-2:0], din};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '1;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign dout = sh_q[STAGES-1];

endmodule

// File: rtl/uart_rxt_deser.sv
module uart_rxt_deser
    import uart_rxt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rx,
    input  logic [3:0] len,
    input  par_mode_e  par_mode,
    output logic       push,
    output rx_entry_t  entry
);

    localparam int TICKS   = 16;
    localparam int HALF    = TICKS / 2;
    localparam int TCNT_W  = $clog2(TICKS);

    typedef struct packed {
        rx_state_e         st;
        logic [TCNT_W-1:0] tcnt;
        logic [3:0]        bcnt;
        logic [DATA_W-1:0] shreg;
        logic              par_acc;
        logic              perr;
        logic              push;
        rx_entry_t         ent;
    } deser_s;

    deser_s d, q;
    logic   mid_bit;
    logic   par_total;
    logic [3:0] shamt;

    always_comb begin
        d         = q;
        d.push    = 1'b0;
        mid_bit   = (q.tcnt == TCNT_W'(TICKS - 1));
        par_total = q.par_acc ^ rx;
        shamt     = 4'(DATA_W) - len;
        if (tick) begin
            case (q.st)
                RX_IDLE: begin
                    if (!rx) begin
                        d.st   = RX_START;
                        d.tcnt = '0;
                    end
                end
                RX_START: begin
                    d.tcnt = q.tcnt + 1'b1;
                    if (q.tcnt == TCNT_W'(HALF - 1)) begin
                        if (!rx) begin
                            d.st      = RX_DATA;
                            d.tcnt    = '0;
                            d.bcnt    = '0;
                            d.shreg   = '0;
                            d.par_acc = 1'b0;
                            d.perr    = 1'b0;
                        end else begin
                            d.st = RX_IDLE;
                        end
                    end
                end
                RX_DATA: begin
                    d.tcnt = q.tcnt + 1'b1;
                    if (mid_bit) begin
                        d.shreg   = {rx, q.shreg[DATA_W-1:1]};
                        d.par_acc = par_total;
                        d.bcnt    = q.bcnt + 1'b1;
                        if (q.bcnt == len - 4'd1) begin
                            d.st = (par_mode == PAR_NONE) ? RX_STOP : RX_PARITY;
                        end
                    end
                end
                RX_PARITY: begin
                    d.tcnt = q.tcnt + 1'b1;
                    if (mid_bit) begin
                        d.perr = (par_mode == PAR_ODD) ? !par_total : par_total;
                        d.st   = RX_STOP;
                    end
                end
                RX_STOP: begin
                    d.tcnt = q.tcnt + 1'b1;
                    if (mid_bit) begin
                        d.push      = 1'b1;
                        d.ent.data  = q.shreg >> shamt;
                        d.ent.perr  = (par_mode != PAR_NONE) && q.perr;
                        d.ent.ferr  = !rx;
                        d.st        = RX_IDLE;
                    end
                end
                default: d.st = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: RX_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign push  = q.push;
    assign entry = q.ent;

endmodule

// File: rtl/uart_rxt_hold.sv
module uart_rxt_hold
    import uart_rxt_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push,
    input  rx_entry_t push_entry,
    input  logic      pop,
    output rx_entry_t head,
    output logic      not_empty,
    output logic      ovf
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        rx_entry_t [DEPTH-1:0] mem;
        logic [PTR_W-1:0]      wp;
        logic [PTR_W-1:0]      rp;
        logic [CNT_W-1:0]      cnt;
        logic                  ovf;
    } hold_s;

    hold_s d, q;
    logic  do_pop;
    logic  do_push;

    function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        d       = q;
        do_pop  = pop && (q.cnt != '0);
        do_push = push && ((q.cnt != CNT_W'(DEPTH)) || do_pop);
        d.ovf   = push && !do_push;
        if (do_push) begin
            d.mem[q.wp] = push_entry;
            d.wp        = next_ptr(q.wp);
        end
        if (do_pop) begin
            d.rp = next_ptr(q.rp);
        end
        case ({do_push, do_pop})
            2'b10:   d.cnt = q.cnt + 1'b1;
            2'b01:   d.cnt = q.cnt - 1'b1;
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign not_empty = (q.cnt != '0);
    assign head      = not_empty ? q.mem[q.rp] : '0;
    assign ovf       = q.ovf;

endmodule

// File: rtl/uart_rxt_top.sv
module uart_rxt_top
    import uart_rxt_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int BUF_DEPTH   = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick16,
    input  logic        rxd,
    input  logic [15:0] cfg_word,
    input  logic        rd_pop,
    output logic [15:0] rd_word,
    output logic        data_valid,
    output logic        overflow
);

    logic       rx_s;
    logic [3:0] len;
    par_mode_e  par_mode;
    logic       push;
    rx_entry_t  new_entry;
    rx_entry_t  head;
    logic       unused_cfg;

    assign len        = decode_len(cfg_word[3:0]);
    assign par_mode   = decode_par(cfg_word[9:8]);
    assign unused_cfg = ^{cfg_word[15:10], cfg_word[7:4]};

    uart_rxt_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rxd),
        .dout (rx_s)
    );

    uart_rxt_deser deser_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick16),
        .rx      (rx_s),
        .len     (len),
        .par_mode(par_mode),
        .push    (push),
        .entry   (new_entry)
    );

    uart_rxt_hold #(.DEPTH(BUF_DEPTH)) hold_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_entry(new_entry),
        .pop       (rd_pop),
        .head      (head),
        .not_empty (data_valid),
        .ovf       (overflow)
    );

    assign rd_word = pack_word(head);

endmodule

// File: rtl/uart_rxt_checker.sv
module uart_rxt_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        rd_pop,
    input logic [15:0] rd_word,
    input logic        data_valid,
    input logic        overflow
);

    assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_word[13:9] == 5'd0);

    assert_empty_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !data_valid |-> rd_word == 16'h0000);

    assert_head_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (data_valid && !rd_pop) |=> $stable(rd_word));

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> data_valid);

    assert_ovf_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> !overflow);

    assert_pop_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_valid && !overflow) |=> !overflow);

endmodule

bind uart_rxt_top uart_rxt_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_pop    (rd_pop),
    .rd_word   (rd_word),
    .data_valid(data_valid),
    .overflow  (overflow)
);

// File: tb/uart_rxt_top_tb.sv
module uart_rxt_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int BIT_CLKS   = 16;
    localparam int N_VEC      = 8;

    typedef struct packed {
        logic [15:0] cfg;
        logic [7:0]  dat;
        logic        flip_par;
        logic        bad_stop;
        logic [15:0] exp;
    } vec_t;

    localparam vec_t VECS [N_VEC] = '{
        '{16'h1005, 8'hA5, 1'b0, 1'b0, 16'h00A5},
        '{16'h1202, 8'h13, 1'b0, 1'b0, 16'h0013},
        '{16'h1304, 8'h55, 1'b0, 1'b0, 16'h0055},
        '{16'h1205, 8'h3C, 1'b1, 1'b0, 16'h403C},
        '{16'h1003, 8'h2A, 1'b0, 1'b1, 16'h802A},
        '{16'h1305, 8'h00, 1'b0, 1'b1, 16'h8000},
        '{16'h1105, 8'h81, 1'b0, 1'b0, 16'h0081},
        '{16'h1302, 8'h1F, 1'b1, 1'b0, 16'h401F}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick16 = 1'b1;
    logic        rxd = 1'b1;
    logic [15:0] cfg_word = 16'h1005;
    logic        rd_pop = 1'b0;
    logic [15:0] rd_word;
    logic        data_valid;
    logic        overflow;

    int checks = 0;
    int errors = 0;
    int ovf_cnt = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    uart_rxt_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick16    (tick16),
        .rxd       (rxd),
        .cfg_word  (cfg_word),
        .rd_pop    (rd_pop),
        .rd_word   (rd_word),
        .data_valid(data_valid),
        .overflow  (overflow)
    );

    always @(negedge clk) begin
        if (rst_n && overflow) ovf_cnt++;
    end

    task automatic check(input string rq, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        rxd = b;
        idle(BIT_CLKS);
    endtask

    task automatic send_frame(input logic [15:0] cfg_v, input logic [7:0] dat,
                              input logic flip_par, input logic bad_stop, input int gap);
        int    len;
        logic  par;
        len = int'(cfg_v[3:0]) + 3;
        if (len < 5) len = 5;
        if (len > 8) len = 8;
        par = 1'b0;
        send_bit(1'b0);
        for (int i = 0; i < len; i++) begin
            send_bit(dat[i]);
            par = par ^ dat[i];
        end
        if (cfg_v[9]) begin
            if (cfg_v[8]) par = ~par;
            send_bit(par ^ flip_par);
        end
        send_bit(!bad_stop);
        rxd = 1'b1;
        idle(gap);
    endtask

    task automatic pop_one();
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R9: reset state
        check("R9 data_valid", {15'd0, data_valid}, 16'h0000);
        check("R9 rd_word", rd_word, 16'h0000);
        check("R9 overflow", {15'd0, overflow}, 16'h0000);

        // Vector table: R1 R2 R3 R6 R7 R10
        for (int v = 0; v < N_VEC; v++) begin
            cfg_word = VECS[v].cfg;
            send_frame(VECS[v].cfg, VECS[v].dat, VECS[v].flip_par, VECS[v].bad_stop, 40);
            check($sformatf("R6 valid vector %0d", v), {15'd0, data_valid}, 16'h0001);
            check($sformatf("R1 R2 R3 R10 word vector %0d", v), rd_word, VECS[v].exp);
            pop_one();
            check($sformatf("R7 drained vector %0d", v), {15'd0, data_valid}, 16'h0000);
        end

        // R5: short low glitch is a false start
        cfg_word = 16'h1005;
        rxd = 1'b0;
        idle(4);
        rxd = 1'b1;
        idle(60);
        check("R5 glitch stores nothing", {15'd0, data_valid}, 16'h0000);

        // R7: pop while empty has no effect
        pop_one();
        check("R7 pop empty word", rd_word, 16'h0000);
        send_frame(16'h1005, 8'h6E, 1'b0, 1'b0, 40);
        check("R7 after empty pop head", rd_word, 16'h006E);
        pop_one();
        check("R7 after empty pop drained", {15'd0, data_valid}, 16'h0000);

        // R8: third character with full buffer is dropped
        ovf_cnt = 0;
        send_frame(16'h1005, 8'h11, 1'b0, 1'b0, 20);
        send_frame(16'h1005, 8'h22, 1'b0, 1'b0, 20);
        check("R8 no overflow yet", ovf_cnt[15:0], 16'h0000);
        send_frame(16'h1005, 8'h33, 1'b0, 1'b0, 40);
        check("R8 overflow pulse count", ovf_cnt[15:0], 16'h0001);
        check("R8 R6 oldest kept", rd_word, 16'h0011);
        pop_one();
        check("R8 R6 second kept", rd_word, 16'h0022);
        pop_one();
        check("R8 dropped not stored", {15'd0, data_valid}, 16'h0000);

        // R4: two-stop setting, frames with one stop bit back to back
        cfg_word = 16'h3005;
        send_frame(16'h3005, 8'h5A, 1'b0, 1'b0, 0);
        send_frame(16'h3005, 8'hC3, 1'b0, 1'b0, 40);
        check("R4 first frame", rd_word, 16'h005A);
        pop_one();
        check("R4 second frame", rd_word, 16'h00C3);
        pop_one();
        cfg_word = 16'h0005;
        send_frame(16'h0005, 8'h96, 1'b0, 1'b0, 40);
        check("R4 half-stop setting", rd_word, 16'h0096);
        pop_one();

        // R1: out-of-range length field acts as 8 bits
        cfg_word = 16'h100F;
        send_frame(16'h1005, 8'hE7, 1'b0, 1'b0, 40);
        check("R1 clamp high length", rd_word, 16'h00E7);
        pop_one();

        finish_run();
    end

endmodule